// File: doc/BRIEF.md
# Peak-Offset Current-Mode Reference Generator

This block drives a three-level flying-capacitor buck stage operated in peak current-programmed mode. It takes four inputs: a current reference word from the outer voltage loop, sampled words for the flying-capacitor voltage and for half the input voltage, and a comparator bit that rises once the inductor current reaches the programmed peak. From these it generates the on-commands for the two switch pairs and the reference word that feeds an external DAC. The two pairs work 180° apart. Each switching period therefore splits into two subperiods of equal length: in the first, pair A charges the flying capacitor, and in the second, pair B discharges it.

Peak control on its own lets the flying capacitor drift, and it is unstable over wide duty ranges. To counter this, the block shifts the peak reference up in one subperiod and down in the next, by the same amount. That amount is the capacitor's deviation from half the input voltage, scaled by a programmable power-of-two gain and limited to one eighth of full scale. The reference is loaded only at subperiod boundaries, so it never changes while a pulse is running. Each pulse starts on the first cycle of its subperiod. A blanking window masks the comparator at the start of the pulse. The pulse ends on the first comparator trip after that window, or at a maximum on-time if no trip arrives.

Top module: `peak_offset_ref_gen`

## Requirements
- R1: While reset is held, both pair commands are low and the reference output is zero.
- R2: Subperiods are SUB_CYC clocks long and alternate strictly. The first subperiod after reset is the charging one (pair A); the next is the discharging one (pair B). Pair A and pair B are never high together.
- R3: The offset is (vHalfIn − vFlyIn) shifted left by gainShift bits, as a signed value, saturated to ±2^(REF_W−3).
- R4: In a charging subperiod the reference is iRefIn + offset. In a discharging subperiod it is iRefIn − offset. When the capacitor sits above half the input, the offset is negative, so the signs swap.
- R5: The reference is clamped to the range 0 to 2^REF_W − 1.
- R6: The reference is loaded from the inputs present on the boundary clock edge and holds for the whole subperiod. Input changes in mid-subperiod have no effect until the next boundary.
- R7: The active pair's pulse is high in the first cycle of every subperiod.
- R8: A comparator trip sampled while the subperiod counter is below BLANK_CYC is ignored.
- R9: A trip sampled at counter value k ≥ BLANK_CYC ends the pulse, giving an on-time of k+1 cycles. The pulse then stays low for the rest of the subperiod, even if the trip bit falls again.
- R10: With no qualifying trip, the pulse ends after MAX_ON cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iRefIn | input | REF_W | Peak current reference from the voltage loop |
| vFlyIn | input | V_W | Sampled flying-capacitor voltage |
| vHalfIn | input | V_W | Sampled half input voltage |
| gainShift | input | GAIN_W | Offset gain as a left-shift count |
| cmpTrip | input | 1 | Inductor current has reached the reference |
| pairA | output | 1 | Charging switch pair on-command |
| pairB | output | 1 | Discharging switch pair on-command |
| dacRef | output | REF_W | Per-subperiod peak reference to the DAC |

## Verification
The hardest case to reach is an input change that lands inside a subperiod, because it must not show up on the DAC word until the next boundary. To provoke it, the stimulus re-randomises all of the reference and voltage inputs halfway through selected subperiods, then compares the DAC word near the end of the subperiod against the value computed at the boundary. A second hard case is the pulse end. Trip patterns are placed before, at and after the blanking limit, some of them short enough to drop again, to confirm that a masked trip is ignored and that a released trip cannot restart the pulse. Directed cases drive the offset into both saturation limits and push the reference sum past both ends of the clamp.

// File: rtl/peak_offset_pkg.sv
package peak_offset_pkg;

  typedef enum logic {
    PH_CHARGE = 1'b0,
    PH_DISCHARGE = 1'b1
  } phase_e;

  typedef struct packed {
    logic   loadRef;
    phase_e nextPhase;
  } strobe_t;

endpackage

// File: rtl/peak_offset_ctrl.sv
module peak_offset_ctrl
  import peak_offset_pkg::*;
#(
  parameter int SUB_CYC   = 64,
  parameter int BLANK_CYC = 4,
  parameter int MAX_ON    = 48
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmpTrip,
  output strobe_t strobe,
  output logic    pairA,
  output logic    pairB
);

  localparam int CNT_W = $clog2(SUB_CYC);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SUB_CYC - 1);
  localparam logic [CNT_W-1:0] BLANK_CNT = CNT_W'(BLANK_CYC);
  localparam logic [CNT_W-1:0] LIMIT_CNT = CNT_W'(MAX_ON - 1);

  logic [CNT_W-1:0] subCnt;
  phase_e           phase;
  logic             pulseOn;
  logic             boundary;
  logic             tripValid;
  logic             endPulse;

  assign boundary  = (subCnt == LAST_CNT);
  assign tripValid = cmpTrip && (subCnt >= BLANK_CNT);
  assign endPulse  = pulseOn && (tripValid || (subCnt == LIMIT_CNT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt  <= LAST_CNT;
      phase   <= PH_DISCHARGE;
      pulseOn <= 1'b0;
    end else if (boundary) begin
      subCnt  <= '0;
      phase   <= (phase == PH_CHARGE) ? PH_DISCHARGE : PH_CHARGE;
      pulseOn <= 1'b1;
    end else begin
      subCnt <= subCnt + 1'b1;
      if (endPulse) pulseOn <= 1'b0;
    end
  end

  always_comb begin
    strobe.loadRef   = boundary;
    strobe.nextPhase = (phase == PH_CHARGE) ? PH_DISCHARGE : PH_CHARGE;
  end

  assign pairA = pulseOn && (phase == PH_CHARGE);
  assign pairB = pulseOn && (phase == PH_DISCHARGE);

  // R2: pairs never conduct together
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(pairA && pairB));

  // R2: phase flips exactly at a boundary
  a_r2_alternate: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> (phase != $past(phase)));

  // R7: every subperiod starts with the pulse on
  a_r7_start_on: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> pulseOn);

  // R8: inside the blanking window the pulse keeps running
  a_r8_blanked: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && (subCnt < BLANK_CNT)) |=> pulseOn);

  // R9: once ended the pulse stays off until the next boundary
  a_r9_stay_off: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseOn && !boundary) |=> !pulseOn);

  // R10: no pulse beyond the on-time limit
  a_r10_max_on: assert property (@(posedge clk) disable iff (!rstN)
    (subCnt > LIMIT_CNT) |-> !pulseOn);

endmodule

// File: rtl/peak_offset_datapath.sv
module peak_offset_datapath
  import peak_offset_pkg::*;
#(
  parameter int REF_W  = 10,
  parameter int V_W    = 10,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [REF_W-1:0]  iRefIn,
  input  logic [V_W-1:0]    vFlyIn,
  input  logic [V_W-1:0]    vHalfIn,
  input  logic [GAIN_W-1:0] gainShift,
  output logic [REF_W-1:0]  dacRef
);

  localparam int ERR_W = V_W + 1;
  localparam int SH_W  = ERR_W + (2 ** GAIN_W) - 1;
  localparam int OFF_W = REF_W - 1;
  localparam int SUM_W = REF_W + 2;
  localparam logic signed [SH_W-1:0]  LIM_POS = SH_W'(2 ** (REF_W - 3));
  localparam logic signed [SH_W-1:0]  LIM_NEG = -LIM_POS;
  localparam logic signed [SUM_W-1:0] REF_MAX = SUM_W'((2 ** REF_W) - 1);

  logic signed [ERR_W-1:0] vErr;
  logic signed [SH_W-1:0]  errExt;
  logic signed [SH_W-1:0]  scaled;
  logic signed [OFF_W-1:0] offset;
  logic signed [SUM_W-1:0] base;
  logic signed [SUM_W-1:0] offExt;
  logic [REF_W-1:0]        cand [2];

  assign vErr   = $signed({1'b0, vHalfIn}) - $signed({1'b0, vFlyIn});
  assign errExt = $signed({{(SH_W - ERR_W){vErr[ERR_W-1]}}, vErr});
  assign scaled = errExt <<< gainShift;

  always_comb begin
    if (scaled > LIM_POS)      offset = OFF_W'(LIM_POS);
    else if (scaled < LIM_NEG) offset = OFF_W'(LIM_NEG);
    else                       offset = OFF_W'(scaled);
  end

  assign base   = $signed({2'b00, iRefIn});
  assign offExt = $signed({{(SUM_W - OFF_W){offset[OFF_W-1]}}, offset});

  for (genvar g = 0; g < 2; g++) begin : gPhase
    logic signed [SUM_W-1:0] raw;
    assign raw = (g == 0) ? (base + offExt) : (base - offExt);
    always_comb begin
      if (raw < 0)             cand[g] = '0;
      else if (raw > REF_MAX)  cand[g] = '1;
      else                     cand[g] = REF_W'(raw);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              dacRef <= '0;
    else if (strobe.loadRef) dacRef <= cand[strobe.nextPhase];
  end

  // R6: reference moves only on a boundary load
  a_r6_hold_ref: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadRef |=> $stable(dacRef));

  // R3: offset never leaves its saturation band
  a_r3_offset_band: assert property (@(posedge clk) disable iff (!rstN)
    (offExt <= SUM_W'(2 ** (REF_W - 3))) && (offExt >= -SUM_W'(2 ** (REF_W - 3))));

  // R4: with zero capacitor error both phases use the bare reference
  a_r4_zero_err: assert property (@(posedge clk) disable iff (!rstN)
    (vHalfIn == vFlyIn) |-> (cand[0] == iRefIn && cand[1] == iRefIn));

endmodule

// File: rtl/peak_offset_ref_gen.sv
module peak_offset_ref_gen
  import peak_offset_pkg::*;
#(
  parameter int REF_W     = 10,
  parameter int V_W       = 10,
  parameter int GAIN_W    = 3,
  parameter int SUB_CYC   = 64,
  parameter int BLANK_CYC = 4,
  parameter int MAX_ON    = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REF_W-1:0]  iRefIn,
  input  logic [V_W-1:0]    vFlyIn,
  input  logic [V_W-1:0]    vHalfIn,
  input  logic [GAIN_W-1:0] gainShift,
  input  logic              cmpTrip,
  output logic              pairA,
  output logic              pairB,
  output logic [REF_W-1:0]  dacRef
);

  strobe_t strobe;

  peak_offset_ctrl #(
    .SUB_CYC  (SUB_CYC),
    .BLANK_CYC(BLANK_CYC),
    .MAX_ON   (MAX_ON)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .cmpTrip(cmpTrip),
    .strobe (strobe),
    .pairA  (pairA),
    .pairB  (pairB)
  );

  peak_offset_datapath #(
    .REF_W (REF_W),
    .V_W   (V_W),
    .GAIN_W(GAIN_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .iRefIn   (iRefIn),
    .vFlyIn   (vFlyIn),
    .vHalfIn  (vHalfIn),
    .gainShift(gainShift),
    .dacRef   (dacRef)
  );

  // R1: outputs are quiet under reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rstN) |-> (!pairA && !pairB && dacRef == '0));

endmodule

// File: tb/peak_offset_ref_gen_test.sv
`timescale 1ns/1ps
module peak_offset_ref_gen_test;

  localparam int REF_W = 10;
  localparam int V_W = 10;
  localparam int GAIN_W = 3;
  localparam int SUB_CYC = 64;
  localparam int BLANK_CYC = 4;
  localparam int MAX_ON = 48;
  localparam int NONE = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [REF_W-1:0] iRefIn = '0;
  logic [V_W-1:0] vFlyIn = '0;
  logic [V_W-1:0] vHalfIn = '0;
  logic [GAIN_W-1:0] gainShift = '0;
  logic cmpTrip = 1'b0;
  logic pairA, pairB;
  logic [REF_W-1:0] dacRef;

  int errors = 0;
  int checks = 0;
  int subIdx = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  peak_offset_ref_gen #(
    .REF_W(REF_W), .V_W(V_W), .GAIN_W(GAIN_W),
    .SUB_CYC(SUB_CYC), .BLANK_CYC(BLANK_CYC), .MAX_ON(MAX_ON)
  ) uut (
    .clk(clk), .rstN(rstN), .iRefIn(iRefIn), .vFlyIn(vFlyIn),
    .vHalfIn(vHalfIn), .gainShift(gainShift), .cmpTrip(cmpTrip),
    .pairA(pairA), .pairB(pairB), .dacRef(dacRef)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (sub %0d)", req, act, exp, subIdx);
    end
  endtask

  // R3/R4/R5 model
  function automatic int expRef(int ir, int vf, int vh, int g, int ph);
    int lim = 1 << (REF_W - 3);
    int off = (vh - vf) * (1 << g);
    int r;
    if (off > lim) off = lim;
    if (off < -lim) off = -lim;
    r = (ph == 0) ? ir + off : ir - off;
    if (r < 0) r = 0;
    if (r > (1 << REF_W) - 1) r = (1 << REF_W) - 1;
    return r;
  endfunction

  // R8/R9/R10 model
  function automatic int expWidth(int tripAt, int tripLen);
    for (int c = 0; c < SUB_CYC; c++) begin
      bit t = (c >= tripAt) && (c < tripAt + tripLen);
      if ((c >= BLANK_CYC && t) || c == MAX_ON - 1) return c + 1;
    end
    return MAX_ON;
  endfunction

  // entered at a negedge where the design counter is at its last value
  task automatic runSub(int tripAt, int tripLen, bit midChange, string tag);
    int ph = subIdx % 2;
    int exp = expRef(iRefIn, vFlyIn, vHalfIn, gainShift, ph);
    int wExp = expWidth(tripAt, tripLen);
    int width = 0;
    for (int c = 0; c < SUB_CYC; c++) begin
      logic act, other;
      @(posedge clk);
      @(negedge clk);
      act = (ph == 0) ? pairA : pairB;
      other = (ph == 0) ? pairB : pairA;
      if (c == 0) begin
        check(dacRef == REF_W'(exp), {tag, " R4 reference"}, dacRef, exp);
        check(act == 1'b1, "R7 pulse starts at boundary", act, 1);
      end
      if (other) check(1'b0, "R2 inactive pair high", 1, 0);
      if (act) width++;
      cmpTrip = (c >= tripAt) && (c < tripAt + tripLen);
      if (midChange && c == SUB_CYC / 2) begin
        iRefIn = REF_W'($urandom);
        vFlyIn = V_W'($urandom);
        vHalfIn = V_W'($urandom);
      end
      if (c == SUB_CYC - 2)
        check(dacRef == REF_W'(exp), "R6 reference held", dacRef, exp);
    end
    check(width == wExp, {tag, " R9/R10 on-time"}, width, wExp);
    subIdx++;
  endtask

  task automatic setIn(int ir, int vf, int vh, int g);
    iRefIn = REF_W'(ir);
    vFlyIn = V_W'(vf);
    vHalfIn = V_W'(vh);
    gainShift = GAIN_W'(g);
  endtask

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pairA == 1'b0 && pairB == 1'b0, "R1 pairs low in reset", int'(pairA | pairB), 0);
    check(dacRef == '0, "R1 reference zero in reset", dacRef, 0);
    rstN = 1'b1;

    // directed: zero error, both phases equal (R4), trip before blanking (R8)
    setIn(400, 300, 300, 0);
    runSub(1, 2, 1'b0, "R2 charge zero-err");
    setIn(400, 300, 300, 0);
    runSub(NONE, 0, 1'b0, "R10 no trip");
    // capacitor low: charge gets +, discharge gets - (R3, R4)
    setIn(500, 290, 300, 2);
    runSub(BLANK_CYC, 1, 1'b0, "R8 trip at blank edge");
    runSub(10, 30, 1'b0, "R4 discharge minus");
    // capacitor high: signs swap
    setIn(500, 310, 300, 1);
    runSub(20, 1, 1'b0, "R9 short trip stays off");
    runSub(MAX_ON - 1, 5, 1'b0, "R4 swapped sign");
    // saturation both directions (R3)
    setIn(500, 0, 1000, 7);
    runSub(15, 40, 1'b0, "R3 saturate positive");
    setIn(500, 1000, 0, 7);
    runSub(15, 40, 1'b0, "R3 saturate negative");
    // clamp high and low (R5)
    setIn(1020, 200, 300, 3);
    runSub(30, 40, 1'b0, "R5 clamp high");
    setIn(3, 200, 300, 3);
    runSub(30, 40, 1'b0, "R5 clamp low");
    // mid-subperiod change (R6)
    setIn(600, 100, 140, 1);
    runSub(25, 3, 1'b1, "R6 mid change");
    runSub(25, 3, 1'b1, "R6 mid change");

    // constrained random
    for (int n = 0; n < 36; n++) begin
      int ta = ($urandom % 4 == 0) ? NONE : int'($urandom % SUB_CYC);
      int tl = 1 + int'($urandom % 12);
      iRefIn = REF_W'($urandom);
      vHalfIn = V_W'(256 + $urandom % 512);
      vFlyIn = V_W'(int'(vHalfIn) - 40 + int'($urandom % 81));
      gainShift = GAIN_W'($urandom);
      runSub(ta, tl, ($urandom % 3) == 0, "R2 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL all watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule